// File: doc/BRIEF.md
# Burst Backing Memory with Fixed Latency

This block stands behind a cache controller as its next memory level and answers line requests with a fixed, DRAM-like schedule. A request carries a start word address, a direction (read or write) and a length choice of one word or one full aligned block of four words. Once a request is taken, the memory waits a long first-access latency before the first word moves. Each further word of the burst then follows after a shorter per-word period. Storage is an internal register array that is cleared by reset.

The request side is a valid/ready channel. The requester raises `req_valid` with stable `req_write`, `req_long` and `req_addr` and holds them until a cycle in which `req_ready` is also high. That cycle is the accept cycle. Only one request is open at a time: `req_ready` is low for as long as `busy` is high. The data side has no back-pressure, because the schedule is fixed. Read words show up on `rd_data` for one cycle, marked by `rd_valid`, and the requester must take them then. For a write burst the memory pulses `wr_ready` in each word slot and takes `wr_data` in that same cycle, so the requester must already be driving the right word whenever a pulse can come.

Burst words come from consecutive addresses counting up from the start word and wrapping inside the aligned four-word block. A requester can therefore start at the word it needs most and still receive the whole line.

Top module: `bmem_burst_model`

## Requirements
- R1: Right after reset, `req_ready` is 1 and `busy`, `rd_valid`, `wr_ready` and `done` are 0.
- R2: A request is taken at the rising edge where `req_valid` and `req_ready` are both high. `busy` is 1 from the next cycle through the cycle of `done`, and `req_ready` is the inverse of `busy`.
- R3: Take the cycle after the accepting edge as cycle 0. The first word moves in cycle 50. A single-word access therefore spans 1 accept cycle, 50 latency cycles and 1 return cycle, which is 52 cycles.
- R4: Each later word of a burst moves 10 cycles after the previous one, so the last of four words moves in cycle 80 (82 cycles in all).
- R5: Word k of a burst uses address bits [5:2] from `req_addr` and low bits `(req_addr[1:0] + k) mod 4`, so the burst wraps inside the aligned four-word block.
- R6: With `req_long` = 0 the burst is one word. With `req_long` = 1 it is four words.
- R7: In a read burst, `rd_valid` is high for exactly one cycle per word and `rd_data` holds the array word at that word's address. `rd_valid` and `wr_ready` are never high together.
- R8: In a write burst, `wr_ready` is high for exactly one cycle per word. The `wr_data` value in that cycle is stored at that word's address, and later reads return it.
- R9: `done` is a one-cycle pulse in the cycle of the burst's last word. In the following cycle `busy` is 0 and `req_ready` is 1.
- R10: A `req_valid` raised while `busy` is high is ignored. It starts no burst and changes no array word.
- R11: Reset clears every array word to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Memory idle, can take a request |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_long | input | 1 | 1 = four-word burst, 0 = single word |
| req_addr | input | 6 | Start word address; low 2 bits are the offset inside the block |
| rd_valid | output | 1 | Read word present this cycle |
| rd_data | output | 32 | Read word, zero when `rd_valid` is low |
| wr_ready | output | 1 | Write word taken this cycle |
| wr_data | input | 32 | Write word, sampled when `wr_ready` is high |
| busy | output | 1 | A burst is in progress |
| done | output | 1 | Last word of the burst moves this cycle |

## Verification
The bench predicts the exact cycle of every word strobe from the accept edge. A latency counter that is off by one in its first or repeat period would make a strobe arrive one cycle early or late, and the bench reports it as a mistimed or missing beat. Bursts that start at offsets 2 and 3 check the in-block wrap: a design that carries into the upper address bits would read or write a neighbouring block, and the later read-back shows the wrong data. Another test holds a write request active for many cycles of a running read burst. A design that accepted it would produce extra beats or corrupt the block, and the bench catches both. The bench also checks that `done` lines up with the last word, and that the memory is free again in the very next cycle.

// File: rtl/bmem_pkg.sv
package bmem_pkg;

  // Direction of the burst held while busy
  typedef enum logic {
    DIR_READ  = 1'b0,
    DIR_WRITE = 1'b1
  } bmem_dir_e;

endpackage

// File: rtl/bmem_timer.sv
// Beat timing: first beat FIRST_LAT cycles after the start, then one every NEXT_LAT cycles.
module bmem_timer #(
  parameter int FIRST_LAT = 50,
  parameter int NEXT_LAT  = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic busy,
  output logic beat
);
  localparam int MAXL = (FIRST_LAT > NEXT_LAT) ? FIRST_LAT : NEXT_LAT;
  localparam int CW   = $clog2(MAXL + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (start) begin
      cnt_q <= CW'(FIRST_LAT);
    end else if (busy) begin
      if (cnt_q == '0) cnt_q <= CW'(NEXT_LAT - 1);
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign beat = busy && (cnt_q == '0);

  // No beat can happen in the cycle right after a start
  AST_NO_EARLY_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !beat); // R3

endmodule

// File: rtl/bmem_addr_gen.sv
// Word address of the current beat; the offset wraps within the aligned block.
module bmem_addr_gen #(
  parameter int AW        = 6,
  parameter int BLK_WORDS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic          advance,
  output logic [AW-1:0] cur_addr
);
  localparam int OFF_W = $clog2(BLK_WORDS);

  logic [AW-OFF_W-1:0] base_q;
  logic [OFF_W-1:0]    off_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      off_q  <= '0;
    end else if (load) begin
      base_q <= load_addr[AW-1:OFF_W];
      off_q  <= load_addr[OFF_W-1:0];
    end else if (advance) begin
      off_q  <= off_q + 1'b1;
    end
  end

  assign cur_addr = {base_q, off_q};

  AST_OFFSET_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !load) |=> (off_q == OFF_W'($past(off_q) + 1'b1))); // R5

  AST_BASE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !load) |=> $stable(base_q)); // R5

endmodule

// File: rtl/bmem_array.sv
// Word storage: asynchronous read, one synchronous write per cycle, cleared by reset.
module bmem_array #(
  parameter int AW = 6,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 2 ** AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q[addr] <= wdata;
    end
  end

  assign rdata = mem_q[addr];

endmodule

// File: rtl/bmem_burst_model.sv
module bmem_burst_model
  import bmem_pkg::*;
#(
  parameter int DW        = 32,
  parameter int AW        = 6,
  parameter int BLK_WORDS = 4,
  parameter int FIRST_LAT = 50,
  parameter int NEXT_LAT  = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic          req_long,
  input  logic [AW-1:0] req_addr,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          wr_ready,
  input  logic [DW-1:0] wr_data,
  output logic          busy,
  output logic          done
);
  localparam int IW = $clog2(BLK_WORDS);

  logic          busy_q;
  bmem_dir_e     dir_q;
  logic [IW-1:0] idx_q;
  logic [IW-1:0] last_idx_q;
  logic          accept;
  logic          beat;
  logic          last_beat;
  logic [AW-1:0] cur_addr;
  logic [DW-1:0] arr_rdata;

  assign accept    = req_valid && !busy_q;
  assign last_beat = beat && (idx_q == last_idx_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      dir_q      <= DIR_READ;
      idx_q      <= '0;
      last_idx_q <= '0;
    end else if (accept) begin
      busy_q     <= 1'b1;
      dir_q      <= req_write ? DIR_WRITE : DIR_READ;
      idx_q      <= '0;
      last_idx_q <= req_long ? IW'(BLK_WORDS - 1) : '0;
    end else if (beat) begin
      idx_q <= idx_q + 1'b1;
      if (last_beat) busy_q <= 1'b0;
    end
  end

  bmem_timer #(
    .FIRST_LAT(FIRST_LAT),
    .NEXT_LAT (NEXT_LAT)
  ) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .start(accept),
    .busy (busy_q),
    .beat (beat)
  );

  bmem_addr_gen #(
    .AW       (AW),
    .BLK_WORDS(BLK_WORDS)
  ) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_addr(req_addr),
    .advance  (beat),
    .cur_addr (cur_addr)
  );

  bmem_array #(
    .AW(AW),
    .DW(DW)
  ) u_array (
    .clk  (clk),
    .rst_n(rst_n),
    .addr (cur_addr),
    .we   (beat && (dir_q == DIR_WRITE)),
    .wdata(wr_data),
    .rdata(arr_rdata)
  );

  assign req_ready = !busy_q;
  assign busy      = busy_q;
  assign rd_valid  = beat && (dir_q == DIR_READ);
  assign wr_ready  = beat && (dir_q == DIR_WRITE);
  assign rd_data   = rd_valid ? arr_rdata : '0;
  assign done      = last_beat;

  // Cycles since the accept or since the previous beat, used only by the spacing check
  localparam int GW      = $clog2(FIRST_LAT + 2);
  localparam int GAP_MAX = FIRST_LAT + 1;
  logic [GW-1:0] gap_q;
  logic          gap_from_beat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_q           <= '0;
      gap_from_beat_q <= 1'b0;
    end else if (req_valid && req_ready) begin
      gap_q           <= '0;
      gap_from_beat_q <= 1'b0;
    end else if (rd_valid || wr_ready) begin
      gap_q           <= GW'(1);
      gap_from_beat_q <= 1'b1;
    end else if (gap_q != GW'(GAP_MAX)) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  AST_BEAT_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid || wr_ready) |->
      (gap_q == (gap_from_beat_q ? GW'(NEXT_LAT) : GW'(FIRST_LAT)))); // R3

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy); // R2

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> (busy && !req_ready)); // R10

  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!busy && req_ready && !done)); // R9

  AST_DIR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && wr_ready)); // R7

  AST_DONE_ON_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rd_valid || wr_ready)); // R9

endmodule

// File: tb/tb_bmem_burst_model.sv
`timescale 1ns/1ps
module tb_bmem_burst_model;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic        req_long = 1'b0;
  logic [5:0]  req_addr = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        wr_ready;
  logic [31:0] wr_data = '0;
  logic        busy;
  logic        done;

  always #4 clk = ~clk;

  bmem_burst_model dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_long(req_long), .req_addr(req_addr),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .wr_ready(wr_ready), .wr_data(wr_data),
    .busy(busy), .done(done)
  );

  typedef struct {
    longint      cyc;
    bit          wr;
    logic [31:0] data;
    bit          last;
    string       ttag;
    string       dtag;
  } ev_t;

  ev_t         exq[$];
  logic [31:0] wdq[$];
  logic [31:0] model [64];
  longint      cyc = 0;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          pop_pending = 0;
  bit          rel_pending = 0;
  bit          finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Scoreboard monitor, sampling away from the active edge
  always @(negedge clk) begin
    if (pop_pending) begin
      void'(wdq.pop_front());
      pop_pending = 0;
    end
    if (rel_pending) begin
      chk(!busy && req_ready, "R9", "release after done", {busy, req_ready}, 2'b01);
      rel_pending = 0;
    end
    if (rst_n && (rd_valid || wr_ready)) begin
      if (exq.size() == 0) begin
        chk(0, "R10", "unexpected beat at cycle", cyc, 0);
      end else begin
        ev_t e;
        e = exq.pop_front();
        chk(cyc == e.cyc, e.ttag, "beat cycle", cyc, e.cyc);
        chk(wr_ready == e.wr, "R7", "beat direction", wr_ready, e.wr);
        if (!e.wr) chk(rd_data == e.data, e.dtag, "read word", rd_data, e.data);
        chk(done == e.last, "R9", "done on last beat", done, e.last);
        if (wr_ready) pop_pending = 1;
      end
      rel_pending = done;
    end else if (exq.size() > 0 && cyc > exq[0].cyc) begin
      chk(0, "R6", "missing beat at cycle", cyc, exq[0].cyc);
      void'(exq.pop_front());
    end
    wr_data = (wdq.size() > 0) ? wdq[0] : '0;
  end

  task automatic issue(input bit wr, input bit lng, input logic [5:0] a,
                       input logic [31:0] wd [4], input string dtag);
    longint acc;
    int n;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_long = lng; req_addr = a;
    while (!req_ready) @(negedge clk);
    acc = cyc;
    n = lng ? 4 : 1;
    for (int k = 0; k < n; k++) begin
      ev_t e;
      logic [5:0] ad;
      ad = {a[5:2], 2'(a[1:0] + 2'(k))};
      e.cyc = acc + 1 + 50 + 10 * k;
      e.wr = wr;
      e.last = (k == n - 1);
      e.ttag = (k == 0) ? "R3" : "R4";
      e.dtag = dtag;
      if (wr) begin
        e.data = wd[k];
        model[ad] = wd[k];
        wdq.push_back(wd[k]);
      end else begin
        e.data = model[ad];
      end
      exq.push_back(e);
    end
    @(negedge clk);
    req_valid = 0;
    chk(busy && !req_ready, "R2", "busy after accept", {busy, req_ready}, 2'b10);
  endtask

  task automatic drain();
    while (exq.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] z [4];
    logic [31:0] wa [4];
    logic [31:0] wb [4];
    logic [31:0] ws [4];
    for (int i = 0; i < 64; i++) model[i] = '0;
    z  = '{32'h0, 32'h0, 32'h0, 32'h0};
    wa = '{32'hA000_0000, 32'hA111_1111, 32'hA222_2222, 32'hA333_3333};
    wb = '{32'hB000_0B00, 32'hB111_0B11, 32'hB222_0B22, 32'hB333_0B33};
    ws = '{32'h5EED_0D0D, 32'h0, 32'h0, 32'h0};

    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk(req_ready && !busy && !rd_valid && !wr_ready && !done, "R1", "reset outputs",
        {req_ready, busy, rd_valid, wr_ready, done}, 5'b10000);

    issue(0, 0, 6'd5, z, "R11");       // single read of a cleared word
    issue(1, 1, 6'd8, wa, "R8");       // four-word write from offset 0
    issue(0, 1, 6'd8, z, "R8");        // read back in order
    issue(0, 1, 6'd10, z, "R5");       // start at offset 2: 10,11,8,9
    issue(1, 0, 6'd13, ws, "R8");      // single write
    issue(0, 0, 6'd13, z, "R6");       // single read returns it
    issue(1, 1, 6'd23, wb, "R5");      // write from offset 3: 23,20,21,22
    issue(0, 1, 6'd20, z, "R5");       // read the block from its base

    // R10: hold a write request high during a running read burst
    issue(0, 1, 6'd8, z, "R7");
    @(negedge clk);
    req_valid = 1; req_write = 1; req_long = 1; req_addr = 6'd8;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (i == 30) chk(!req_ready, "R10", "ready low while busy", req_ready, 0);
    end
    req_valid = 0; req_write = 0; req_long = 0;
    drain();
    issue(0, 1, 6'd8, z, "R10");       // block unchanged by the ignored request
    drain();

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule